// File: doc/BRIEF.md
# Two-Phase Persistence Flush Sequencer

This block sits on the host side of a coherency domain. It drives a persistence flush across a parameterised number of attached memory devices when an upstream trigger arrives, for example an early warning of power loss. The sequence has two ordered phases. The first phase asks every device to stop issuing new traffic and to write back its cache. The second phase asks every device to move its held data into persistent media.

A barrier cycle separates the phases. No phase-two request is sent until every device has answered the first phase. Each phase has its own programmable timeout. One shared counter times the phases and restarts at the start of each phase. A failure in the first phase is broadcast to every device on a per-device flag, so each device can record an unclean shutdown. A failure in the second phase shows only on the sticky error output. Completion and error status stay visible until the next accepted trigger.

Top module: `pflush_seq`

## Requirements
- R1: After reset, all request outputs, all fail flags, `busy_o`, `done_o` and `error_o` are low.
- R2: A high `trig_i` sampled while idle starts phase one. From the next cycle, `drain_req_o` is all ones and `busy_o` is high.
- R3: When phase one ends, exactly one cycle follows with both request vectors all zero. After it, `commit_req_o` is all ones. The two request vectors are never nonzero together.
- R4: Phase two ends once every device has responded. In the next cycle `done_o` is high, `busy_o` is low and both request vectors are zero.
- R5: A phase that is entered with the counter at zero and still lacks a response when the counter equals its limit ends as a failure. The phase therefore lasts at most limit+1 cycles. The counter restarts for each phase. A response that completes the set in the limit cycle wins over the timeout.
- R6: If phase one ends with a device error or a timeout, `fail_flag_o` goes all ones in the barrier cycle. It stays all ones until the next accepted trigger.
- R7: A timeout or device error in phase two sets `error_o` when the sequence ends and leaves `fail_flag_o` low.
- R8: `done_o`, `error_o` and `fail_flag_o` keep their values while idle. An accepted trigger clears all three.
- R9: A trigger that arrives while `busy_o` is high is ignored. The running sequence continues unchanged and is not restarted.
- R10: A device counts as responded once its ack bit or its error bit has been high in any cycle of the current phase. A single-cycle pulse is enough.
- R11: Ack or error bits seen while idle or in the barrier cycle do not count towards any phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_i | input | 1 | Flush trigger, honoured only while idle |
| p1_limit_i | input | TMO_W | Timeout limit for phase one, in cycles beyond the first |
| p2_limit_i | input | TMO_W | Timeout limit for phase two, in cycles beyond the first |
| dev_ack_i | input | NUM_DEV | Per-device acknowledgement of the current phase |
| dev_err_i | input | NUM_DEV | Per-device error report for the current phase |
| drain_req_o | output | NUM_DEV | Phase-one request: stop traffic and write back cache |
| commit_req_o | output | NUM_DEV | Phase-two request: commit held data to persistent media |
| fail_flag_o | output | NUM_DEV | Broadcast phase-one failure indication |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Sticky: sequence finished |
| error_o | output | 1 | Sticky: sequence finished with a failure |

## Verification
Two pairs of events can fall in the same cycle. In the first, the final device acknowledgement lands in the cycle where the phase counter reaches its limit. The bench provokes this by holding all acks back until that exact cycle. It judges the result by a clear barrier cycle with no fail flag, and a clean finish with `error_o` low. In the second, a new trigger coincides with the closing acknowledgement of phase two. The bench expects `done_o` to rise, `busy_o` to drop, and no new phase-one request in the following cycles.

// File: rtl/pflush_pkg.sv
package pflush_pkg;

   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_DRAIN  = 2'd1,
      ST_GAP    = 2'd2,
      ST_COMMIT = 2'd3
   } seq_state_t;

endpackage

// File: rtl/pflush_timer.sv
module pflush_timer #(
   parameter int TMO_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             run,
   input  logic [TMO_W-1:0] limit,
   output logic             expired
);

   logic [TMO_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clr) begin
         cnt_q <= '0;
      end else if (run && (cnt_q != limit)) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign expired = run && (cnt_q == limit);

   // R5: the counter never passes the limit of the running phase
   a_r5_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> (cnt_q <= limit));

   // R5: the counter restarts from zero after a clear
   a_r5_cnt_restart: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (cnt_q == '0));

endmodule

// File: rtl/pflush_collect.sv
module pflush_collect #(
   parameter int NUM_DEV = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clr,
   input  logic               run,
   input  logic [NUM_DEV-1:0] ack,
   input  logic [NUM_DEV-1:0] err,
   output logic               all_now,
   output logic               fault_now
);

   logic [NUM_DEV-1:0] resp_q;
   logic [NUM_DEV-1:0] resp_now;
   logic               err_q;

   for (genvar d = 0; d < NUM_DEV; d++) begin : g_dev
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            resp_q[d] <= 1'b0;
         end else if (clr) begin
            resp_q[d] <= 1'b0;
         end else if (run && (ack[d] || err[d])) begin
            resp_q[d] <= 1'b1;
         end
      end
      assign resp_now[d] = resp_q[d] | (run & (ack[d] | err[d]));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         err_q <= 1'b0;
      end else if (clr) begin
         err_q <= 1'b0;
      end else if (run && (|err)) begin
         err_q <= 1'b1;
      end
   end

   assign all_now   = &resp_now;
   assign fault_now = err_q | (run & (|err));

   // R10: a recorded response is never lost before the phase is cleared
   a_r10_resp_held: assert property (@(posedge clk) disable iff (!rst_n)
      !clr |=> ((resp_q & $past(resp_q)) == $past(resp_q)));

   // R11: nothing is recorded while the collector is idle or clearing
   a_r11_no_stray: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && $past(clr)) |=> (resp_q == '0));

endmodule

// File: rtl/pflush_seq.sv
module pflush_seq
   import pflush_pkg::*;
#(
   parameter int NUM_DEV = 4,
   parameter int TMO_W   = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               trig_i,
   input  logic [TMO_W-1:0]   p1_limit_i,
   input  logic [TMO_W-1:0]   p2_limit_i,
   input  logic [NUM_DEV-1:0] dev_ack_i,
   input  logic [NUM_DEV-1:0] dev_err_i,
   output logic [NUM_DEV-1:0] drain_req_o,
   output logic [NUM_DEV-1:0] commit_req_o,
   output logic [NUM_DEV-1:0] fail_flag_o,
   output logic               busy_o,
   output logic               done_o,
   output logic               error_o
);

   if (NUM_DEV < 1) begin : g_bad_dev
      $error("pflush_seq: NUM_DEV must be at least 1");
   end
   if (TMO_W < 1 || TMO_W > 32) begin : g_bad_tmo
      $error("pflush_seq: TMO_W must lie in 1..32");
   end

   seq_state_t         state_q;
   logic               fail_q, fault_q, done_q, err_q;
   logic               run, clr, expired, all_now, fault_now;
   logic               phase_end, phase_bad;
   logic [TMO_W-1:0]   limit_sel;

   assign run       = (state_q == ST_DRAIN) || (state_q == ST_COMMIT);
   assign clr       = (state_q == ST_IDLE) || (state_q == ST_GAP);
   assign limit_sel = (state_q == ST_COMMIT) ? p2_limit_i : p1_limit_i;
   assign phase_end = run && (all_now || expired);
   assign phase_bad = fault_now || !all_now;

   pflush_timer #(.TMO_W(TMO_W)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (clr),
      .run     (run),
      .limit   (limit_sel),
      .expired (expired)
   );

   pflush_collect #(.NUM_DEV(NUM_DEV)) u_collect (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (clr),
      .run       (run),
      .ack       (dev_ack_i),
      .err       (dev_err_i),
      .all_now   (all_now),
      .fault_now (fault_now)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         fail_q  <= 1'b0;
         fault_q <= 1'b0;
         done_q  <= 1'b0;
         err_q   <= 1'b0;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               if (trig_i) begin
                  state_q <= ST_DRAIN;
                  fail_q  <= 1'b0;
                  fault_q <= 1'b0;
                  done_q  <= 1'b0;
                  err_q   <= 1'b0;
               end
            end
            ST_DRAIN: begin
               if (phase_end) begin
                  state_q <= ST_GAP;
                  if (phase_bad) begin
                     fail_q  <= 1'b1;
                     fault_q <= 1'b1;
                  end
               end
            end
            ST_GAP: begin
               state_q <= ST_COMMIT;
            end
            ST_COMMIT: begin
               if (phase_end) begin
                  state_q <= ST_IDLE;
                  done_q  <= 1'b1;
                  err_q   <= fault_q | phase_bad;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign drain_req_o  = {NUM_DEV{state_q == ST_DRAIN}};
   assign commit_req_o = {NUM_DEV{state_q == ST_COMMIT}};
   assign fail_flag_o  = {NUM_DEV{fail_q}};
   assign busy_o       = (state_q != ST_IDLE);
   assign done_o       = done_q;
   assign error_o      = err_q;

   logic any_drain, any_commit;
   assign any_drain  = |drain_req_o;
   assign any_commit = |commit_req_o;

   // R3: the two phases never request at the same time
   a_r3_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(any_drain && any_commit));

   // R3: phase two starts only after a cycle with no phase-one request
   a_r3_barrier: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(any_commit) |-> !$past(any_drain));

   // R4: completion is reported only when no sequence is running
   a_r4_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !busy_o);

   // R6: the broadcast flag rises only as phase one closes
   a_r6_flag_rise: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fail_q) |-> (state_q == ST_GAP));

   // R7: a finished sequence with a broadcast failure reports an error
   a_r7_flag_err: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && fail_q) |-> error_o);

   // R9: a trigger while busy does not clear the broadcast flag
   a_r9_busy_trig: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && trig_i && fail_q) |=> fail_q);

endmodule

// File: tb/pflush_seq_test.sv
module pflush_seq_test;

   localparam int N  = 4;
   localparam int TW = 8;
   localparam logic [N-1:0] ALL = '1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          trig = 1'b0;
   logic [TW-1:0] l1 = 8'd10, l2 = 8'd10;
   logic [N-1:0]  ack = '0, err = '0;
   logic [N-1:0]  drain, commit, fflag;
   logic          busy, done, error;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   pflush_seq #(.NUM_DEV(N), .TMO_W(TW)) uut (
      .clk(clk), .rst_n(rst_n), .trig_i(trig),
      .p1_limit_i(l1), .p2_limit_i(l2),
      .dev_ack_i(ack), .dev_err_i(err),
      .drain_req_o(drain), .commit_req_o(commit), .fail_flag_o(fflag),
      .busy_o(busy), .done_o(done), .error_o(error)
   );

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic step();
      @(negedge clk);
   endtask

   task automatic start_seq(input int a, input int b);
      step();
      l1 = TW'(a); l2 = TW'(b); trig = 1'b1;
      step();
      trig = 1'b0;
   endtask

   task automatic pulse_ack(input logic [N-1:0] v);
      ack = v; step(); ack = '0;
   endtask

   task automatic t_reset();
      chk("R1 drain", drain, 0);  chk("R1 commit", commit, 0);
      chk("R1 flag", fflag, 0);   chk("R1 busy", busy, 0);
      chk("R1 done", done, 0);    chk("R1 error", error, 0);
   endtask

   task automatic t_clean();
      start_seq(10, 10);
      chk("R2 drain", drain, ALL); chk("R2 busy", busy, 1);
      pulse_ack(ALL);
      chk("R3 gap drain", drain, 0); chk("R3 gap commit", commit, 0);
      step();
      chk("R3 commit", commit, ALL);
      pulse_ack(ALL);
      chk("R4 done", done, 1); chk("R4 busy", busy, 0);
      chk("R4 commit", commit, 0); chk("R4 error", error, 0);
      chk("R4 flag", fflag, 0);
   endtask

   task automatic t_stagger();
      start_seq(10, 10);
      for (int i = 0; i < N; i++) begin
         pulse_ack(N'(1) << i);
         if (i < N - 1) chk("R10 still draining", drain, ALL);
      end
      chk("R10 gap after last pulse", drain, 0);
      step();
      pulse_ack(ALL);
      chk("R10 done", done, 1);
   endtask

   task automatic t_p1_error();
      start_seq(10, 10);
      ack = 4'b1101; err = 4'b0010; step(); ack = '0; err = '0;
      chk("R6 flag in gap", fflag, ALL); chk("R6 gap drain", drain, 0);
      step();
      chk("R6 commit after error", commit, ALL);
      pulse_ack(ALL);
      chk("R6 done", done, 1); chk("R6 error", error, 1);
      for (int i = 0; i < 3; i++) step();
      chk("R8 done held", done, 1); chk("R8 error held", error, 1);
      chk("R8 flag held", fflag, ALL);
      start_seq(10, 10);
      chk("R8 done cleared", done, 0); chk("R8 error cleared", error, 0);
      chk("R8 flag cleared", fflag, 0);
      pulse_ack(ALL); step(); pulse_ack(ALL);
   endtask

   task automatic t_p1_timeout();
      start_seq(3, 10);
      pulse_ack(4'b0111);
      chk("R5 cnt1 drain", drain, ALL);
      step(); step();
      chk("R5 limit cycle drain", drain, ALL); chk("R5 no flag yet", fflag, 0);
      step();
      chk("R5 timed out", drain, 0); chk("R6 flag on timeout", fflag, ALL);
      step();
      pulse_ack(ALL);
      chk("R6 timeout error", error, 1);
   endtask

   task automatic t_p2_timeout();
      start_seq(10, 2);
      for (int i = 0; i < 5; i++) step();
      pulse_ack(ALL);
      step();
      chk("R5 commit cnt0", commit, ALL);
      step(); step();
      chk("R5 commit at limit after restart", commit, ALL);
      step();
      chk("R7 done", done, 1); chk("R7 error", error, 1);
      chk("R7 no flag", fflag, 0);
   endtask

   task automatic t_busy_trig();
      start_seq(10, 10);
      step();
      trig = 1'b1; step(); trig = 1'b0;
      chk("R9 drain kept", drain, ALL); chk("R9 busy", busy, 1);
      pulse_ack(ALL);
      trig = 1'b1; step(); trig = 1'b0;
      chk("R9 commit not restarted", commit, ALL);
      ack = ALL; trig = 1'b1; step(); ack = '0; trig = 1'b0;
      chk("R9 done with coincident trig", done, 1);
      chk("R9 busy low", busy, 0); chk("R9 no drain", drain, 0);
      step();
      chk("R9 stays idle", busy, 0); chk("R9 done kept", done, 1);
   endtask

   task automatic t_stray();
      step();
      pulse_ack(ALL);
      start_seq(10, 10);
      chk("R11 idle ack ignored a", drain, ALL);
      step();
      chk("R11 idle ack ignored b", drain, ALL);
      pulse_ack(ALL);
      ack = ALL; step(); ack = '0;
      chk("R11 commit", commit, ALL);
      step();
      chk("R11 gap ack ignored", commit, ALL);
      pulse_ack(ALL);
      chk("R11 done", done, 1);
   endtask

   task automatic t_race_limit();
      start_seq(3, 10);
      step(); step(); step();
      pulse_ack(ALL);
      chk("R5 ack at limit wins flag", fflag, 0);
      chk("R5 ack at limit gap", drain, 0);
      step();
      pulse_ack(ALL);
      chk("R5 ack at limit no error", error, 0);
   endtask

   task automatic t_zero_limit();
      start_seq(0, 0);
      pulse_ack(ALL);
      chk("R5 zero limit with ack", fflag, 0);
      step();
      step();
      chk("R5 zero limit p2 timeout done", done, 1);
      chk("R5 zero limit p2 error", error, 1);
      chk("R7 zero limit no flag", fflag, 0);
   endtask

   initial begin
      for (int i = 0; i < 4; i++) step();
      t_reset();
      rst_n = 1'b1;
      t_clean();
      t_stagger();
      t_p1_error();
      t_p1_timeout();
      t_p2_timeout();
      t_busy_trig();
      t_stray();
      t_race_limit();
      t_zero_limit();
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule